// File: doc/BRIEF.md
# Memory Version Tag Checker

This block guards every load and store with a small version tag kept per 64-byte block of memory. Software writes a 4-bit version into a tag RAM that sits beside the data array. Afterwards each pointer must carry the same version in its top four address bits, or the access is refused and a fault pulse reports why. Address translation happens upstream. The task-wide enable, the page-level enable, the page's writability and a non-faulting-load flag arrive with each request.

Requests enter one per cycle. Each request produces one response two clock edges later. A response is either a grant or a refusal, and a refusal may carry a one-cycle fault pulse with its kind, the faulting address and the PC. The block also serves two writing opcodes. One sets the tag of a block. The other is a block-initialising write, which clears the block's tag to zero as it is granted. A tag written by one request is seen by a check of the same block in the very next cycle.

Top module: `tag_guard`

## Requirements
- R1: The pointer tag is address bits 63..60; the tag RAM holds one 4-bit tag per 64-byte block, indexed by address bits [6 +: log2(DEPTH)], and every entry is zero after reset.
- R2: A request presented with `req_valid` high in cycle N gives `rsp_valid` high after the second rising edge; with no request, `rsp_valid` and `flt_valid` stay low.
- R3: A load or store is checked only when both `task_en` and `page_en` are 1; otherwise it is granted.
- R4: A pointer tag or a stored tag of 0x0 or 0xF matches anything and never faults.
- R5: A checked load or store whose pointer tag differs from the stored tag is refused, with `flt_valid` high for one cycle, `flt_kind` 1 for a load or 2 for a store, and `flt_addr`/`flt_pc` equal to the request's address and PC.
- R6: A load with `req_nf` = 1 is never refused for a tag difference.
- R7: A set-tag request (opcode 2) with `task_en` = 1 on a writable page stores `req_tag` for the addressed block and is granted.
- R8: A set-tag request with `task_en` = 0 is refused with `flt_kind` 3 and leaves the stored tag unchanged.
- R9: A set-tag request to a page with `page_wr` = 0 (and `task_en` = 1) is refused without a fault pulse and leaves the stored tag unchanged.
- R10: A block-initialising write (opcode 3) is granted and clears the block's stored tag to 0.
- R11: A check in the cycle directly after a tag write to the same block uses the newly written tag.
- R12: Opcodes are 0 load, 1 store, 2 set-tag and 3 block-initialising write; `flt_kind` is 0 whenever `flt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Opcode: 0 load, 1 store, 2 set-tag, 3 block-init write |
| req_addr | input | 64 | Address; bits 63..60 carry the pointer tag |
| req_pc | input | 64 | PC of the requesting instruction |
| req_tag | input | 4 | Tag value for set-tag requests |
| task_en | input | 1 | Task-wide checking enable |
| page_en | input | 1 | Page-level checking enable |
| page_wr | input | 1 | Page is writable |
| req_nf | input | 1 | Load is non-faulting |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access granted |
| flt_valid | output | 1 | One-cycle fault pulse |
| flt_kind | output | 2 | 1 load mismatch, 2 store mismatch, 3 set-tag while disabled |
| flt_addr | output | 64 | Faulting address |
| flt_pc | output | 64 | Faulting PC |

## Verification
The hardest case is a tag write that has not yet reached the RAM when the next request reads the same entry. That happens only when a set-tag or block-initialising write is followed, in the very next cycle, by a load or store to the same block. The stimulus issues such back-to-back pairs with the dependent access carrying both the new tag and a different tag. A stale read would grant where a fault is due, or fault where a grant is due. Refused set-tag requests are followed by a check that would expose any tag that was written by mistake.

// File: rtl/tag_guard_pkg.sv
// Shared opcode and fault-kind encodings for the version tag checker.
package tag_guard_pkg;
    typedef enum logic [1:0] {
        OP_LOAD    = 2'd0,
        OP_STORE   = 2'd1,
        OP_SETTAG  = 2'd2,
        OP_BLKINIT = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FK_NONE   = 2'd0,
        FK_LOAD   = 2'd1,
        FK_STORE  = 2'd2,
        FK_SETOFF = 2'd3
    } fault_e;
endpackage

// File: rtl/tag_store.sv
// Tag RAM: one TAG_W entry per block, synchronous read with write-first
// bypass. Assumes at most one write and one read per cycle; a read at the
// same edge as a write to the same index returns the written value.
module tag_store #(
    parameter int TAG_W = 4,
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [TAG_W-1:0] mem [DEPTH];

    // Storage update: clear all entries on reset, else apply the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_tag;
        end
    end

    // Registered read, forwarding a same-edge write to the same entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rd_tag <= '0;
        else if (wr_en && wr_idx == rd_idx)  rd_tag <= wr_tag;
        else                                 rd_tag <= mem[rd_idx];
    end
endmodule

// File: rtl/tag_judge.sv
// Decision logic: given one request and the stored tag of its block, decide
// grant, fault kind and any tag write. Purely combinational.
module tag_judge
    import tag_guard_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic [1:0]       op,
    input  logic [TAG_W-1:0] ptr_tag,
    input  logic [TAG_W-1:0] mem_tag,
    input  logic [TAG_W-1:0] new_tag,
    input  logic             task_en,
    input  logic             page_en,
    input  logic             page_wr,
    input  logic             nf,
    output logic             grant,
    output logic [1:0]       kind,
    output logic             wr_en,
    output logic [TAG_W-1:0] wr_tag
);
    localparam logic [TAG_W-1:0] WILD_LO = '0;
    localparam logic [TAG_W-1:0] WILD_HI = '1;

    logic wild;
    logic mismatch;

    // Wildcard and mismatch detection for ordinary accesses.
    always_comb begin
        wild     = (ptr_tag == WILD_LO) || (ptr_tag == WILD_HI) ||
                   (mem_tag == WILD_LO) || (mem_tag == WILD_HI);
        mismatch = task_en && page_en && !wild && (ptr_tag != mem_tag);
    end

    // Per-opcode outcome.
    always_comb begin
        grant  = 1'b1;
        kind   = FK_NONE;
        wr_en  = 1'b0;
        wr_tag = '0;
        unique case (op_e'(op))
            OP_LOAD: if (mismatch && !nf) begin
                grant = 1'b0;
                kind  = FK_LOAD;
            end
            OP_STORE: if (mismatch) begin
                grant = 1'b0;
                kind  = FK_STORE;
            end
            OP_SETTAG: begin
                if (!task_en) begin
                    grant = 1'b0;
                    kind  = FK_SETOFF;
                end else if (!page_wr) begin
                    grant = 1'b0;
                end else begin
                    wr_en  = 1'b1;
                    wr_tag = new_tag;
                end
            end
            OP_BLKINIT: begin
                wr_en  = 1'b1;
                wr_tag = '0;
            end
            default: grant = 1'b1;
        endcase
    end
endmodule

// File: rtl/tag_guard.sv
// Version tag checker top. Stage 1 captures the request and reads the tag
// RAM; stage 2 judges, writes any tag and registers the response. Assumes
// the address is already physical in its index bits and that the page
// attributes arrive with the request.
module tag_guard
    import tag_guard_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int TAG_W     = 4,
    parameter int BLK_BYTES = 64,
    parameter int DEPTH     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              task_en,
    input  logic              page_en,
    input  logic              page_wr,
    input  logic              req_nf,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              flt_valid,
    output logic [1:0]        flt_kind,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [ADDR_W-1:0] flt_pc
);
    localparam int OFS_W   = $clog2(BLK_BYTES);
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int TAG_LSB = ADDR_W - TAG_W;

    logic              s1_valid;
    logic [1:0]        s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [ADDR_W-1:0] s1_pc;
    logic [TAG_W-1:0]  s1_new;
    logic              s1_task, s1_page, s1_wr, s1_nf;

    logic [TAG_W-1:0]  mem_tag;
    logic              j_grant, j_wr_en;
    logic [1:0]        j_kind;
    logic [TAG_W-1:0]  j_wr_tag;

    // Stage 1: capture the request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= '0;
            s1_addr  <= '0;
            s1_pc    <= '0;
            s1_new   <= '0;
            s1_task  <= 1'b0;
            s1_page  <= 1'b0;
            s1_wr    <= 1'b0;
            s1_nf    <= 1'b0;
        end else begin
            s1_valid <= req_valid;
            s1_op    <= req_op;
            s1_addr  <= req_addr;
            s1_pc    <= req_pc;
            s1_new   <= req_tag;
            s1_task  <= task_en;
            s1_page  <= page_en;
            s1_wr    <= page_wr;
            s1_nf    <= req_nf;
        end
    end

    tag_store #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_addr[OFS_W +: IDX_W]),
        .rd_tag (mem_tag),
        .wr_en  (s1_valid && j_wr_en),
        .wr_idx (s1_addr[OFS_W +: IDX_W]),
        .wr_tag (j_wr_tag)
    );

    tag_judge #(.TAG_W(TAG_W)) u_judge (
        .op      (s1_op),
        .ptr_tag (s1_addr[TAG_LSB +: TAG_W]),
        .mem_tag (mem_tag),
        .new_tag (s1_new),
        .task_en (s1_task),
        .page_en (s1_page),
        .page_wr (s1_wr),
        .nf      (s1_nf),
        .grant   (j_grant),
        .kind    (j_kind),
        .wr_en   (j_wr_en),
        .wr_tag  (j_wr_tag)
    );

    // Stage 2: register the response and the fault report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            flt_valid <= 1'b0;
            flt_kind  <= FK_NONE;
            flt_addr  <= '0;
            flt_pc    <= '0;
        end else begin
            rsp_valid <= s1_valid;
            rsp_grant <= s1_valid && j_grant;
            flt_valid <= s1_valid && (j_kind != FK_NONE);
            flt_kind  <= s1_valid ? j_kind : FK_NONE;
            flt_addr  <= s1_addr;
            flt_pc    <= s1_pc;
        end
    end
endmodule

// File: rtl/tag_guard_chk.sv
// Protocol checker for tag_guard, attached with bind.
module tag_guard_chk #(
    parameter int ADDR_W = 64,
    parameter int TAG_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              task_en,
    input logic              page_en,
    input logic              req_nf,
    input logic              rsp_valid,
    input logic              rsp_grant,
    input logic              flt_valid,
    input logic [1:0]        flt_kind
);
    localparam int TAG_LSB = ADDR_W - TAG_W;

    assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid, 2));

    assert_kind_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_valid |-> flt_kind == 2'd0);

    assert_fault_refuses_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> rsp_valid && !rsp_grant);

    assert_off_grants_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_op[1] == 1'b0 && !(task_en && page_en), 2)
        |-> rsp_grant);

    assert_wild_grants_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_op[1] == 1'b0 &&
              (req_addr[TAG_LSB +: TAG_W] == '0 || req_addr[TAG_LSB +: TAG_W] == '1), 2)
        |-> rsp_grant);

    assert_nf_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_op == 2'd0 && req_nf, 2) |-> rsp_grant && !flt_valid);

    assert_setoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_op == 2'd2 && !task_en, 2) |-> flt_valid && flt_kind == 2'd3);

    assert_blkinit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_op == 2'd3, 2) |-> rsp_grant);
endmodule

bind tag_guard tag_guard_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .task_en   (task_en),
    .page_en   (page_en),
    .req_nf    (req_nf),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .flt_valid (flt_valid),
    .flt_kind  (flt_kind)
);

// File: tb/tag_guard_bench.sv
module tag_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [63:0] req_addr = '0;
    logic [63:0] req_pc = '0;
    logic [3:0]  req_tag = '0;
    logic        task_en = 1'b0, page_en = 1'b0, page_wr = 1'b0, req_nf = 1'b0;
    logic        rsp_valid, rsp_grant, flt_valid;
    logic [1:0]  flt_kind;
    logic [63:0] flt_addr, flt_pc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string       rq;
        logic        grant;
        logic [1:0]  kind;
        logic [63:0] addr;
        logic [63:0] pc;
    } exp_t;
    exp_t sb[$];
    logic [3:0] model [64];

    always #10 clk = ~clk;

    tag_guard u_tag_guard (.*);

    // Driver: present one request and push its expected outcome.
    task automatic issue(input logic [1:0] op, input logic [3:0] ptag, input int blk,
                         input logic [3:0] ntag, input logic te, input logic pe,
                         input logic wr, input logic nf, input string rq);
        exp_t e;
        logic [63:0] a;
        logic [3:0] st;
        logic wild;
        a = {ptag, 48'h0, 6'(blk), 6'h15};
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_pc = a ^ 64'h1234;
        req_tag = ntag; task_en = te; page_en = pe; page_wr = wr; req_nf = nf;
        st = model[blk];
        wild = ptag == 4'h0 || ptag == 4'hF || st == 4'h0 || st == 4'hF;
        e.rq = rq; e.addr = a; e.pc = a ^ 64'h1234; e.grant = 1'b1; e.kind = 2'd0;
        case (op)
            2'd0, 2'd1: if (te && pe && !(op == 2'd0 && nf) && !wild && ptag != st) begin
                e.grant = 1'b0; e.kind = (op == 2'd0) ? 2'd1 : 2'd2;
            end
            2'd2: if (!te) begin e.grant = 1'b0; e.kind = 2'd3; end
                  else if (!wr) e.grant = 1'b0;
                  else model[blk] = ntag;
            default: model[blk] = 4'h0;
        endcase
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each response with the front of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                checks++; failures++;
                $display("FAIL R2 unexpected response act=1 exp=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (rsp_grant !== e.grant || flt_valid !== (e.kind != 0) || flt_kind !== e.kind ||
                    (e.kind != 0 && (flt_addr !== e.addr || flt_pc !== e.pc))) begin
                    failures++;
                    $display("FAIL %s act grant=%b kind=%0d addr=%h exp grant=%b kind=%0d addr=%h",
                             e.rq, rsp_grant, flt_kind, flt_addr, e.grant, e.kind, e.addr);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || flt_valid !== 1'b0) begin
            failures++;
            $display("FAIL R2 reset act=%b%b exp=00", rsp_valid, flt_valid);
        end
        issue(2'd0, 4'h5, 3, 4'h0, 1, 1, 1, 0, "R1 fresh block zero tag");
        issue(2'd2, 4'h0, 3, 4'hA, 1, 1, 1, 0, "R7 set tag");
        issue(2'd0, 4'hA, 3, 4'h0, 1, 1, 1, 0, "R11 bypass load match");
        issue(2'd0, 4'h3, 3, 4'h0, 1, 1, 1, 0, "R5 load mismatch");
        issue(2'd1, 4'h3, 3, 4'h0, 1, 1, 1, 0, "R5 store mismatch");
        issue(2'd2, 4'h0, 9, 4'h6, 1, 1, 1, 0, "R7 set other block");
        issue(2'd1, 4'h2, 9, 4'h0, 1, 1, 1, 0, "R11 bypass store mismatch");
        issue(2'd1, 4'hF, 3, 4'h0, 1, 1, 1, 0, "R4 pointer wildcard F");
        issue(2'd0, 4'h0, 3, 4'h0, 1, 1, 1, 0, "R4 pointer wildcard 0");
        issue(2'd0, 4'h3, 3, 4'h0, 1, 1, 1, 1, "R6 non-faulting load");
        issue(2'd0, 4'h3, 3, 4'h0, 0, 1, 1, 0, "R3 task disabled");
        issue(2'd1, 4'h3, 3, 4'h0, 1, 0, 1, 0, "R3 page disabled");
        issue(2'd1, 4'h1, 9, 4'h0, 1, 1, 1, 1, "R6 nf flag ignored on store");
        idle();
        issue(2'd2, 4'h0, 3, 4'h7, 0, 1, 1, 0, "R8 set tag while disabled");
        issue(2'd0, 4'h7, 3, 4'h0, 1, 1, 1, 0, "R8 tag unchanged");
        issue(2'd2, 4'h0, 3, 4'h4, 1, 1, 0, 0, "R9 set tag read-only");
        issue(2'd1, 4'h4, 3, 4'h0, 1, 1, 1, 0, "R9 tag unchanged");
        issue(2'd2, 4'h0, 5, 4'hF, 1, 1, 1, 0, "R7 store wildcard tag");
        issue(2'd0, 4'h8, 5, 4'h0, 1, 1, 1, 0, "R4 stored wildcard F");
        issue(2'd3, 4'h2, 3, 4'h0, 1, 1, 1, 0, "R10 block init");
        issue(2'd0, 4'h3, 3, 4'h0, 1, 1, 1, 0, "R10 tag cleared");
        issue(2'd2, 4'h0, 63, 4'hC, 1, 1, 1, 0, "R1 top index set");
        issue(2'd0, 4'hD, 63, 4'h0, 1, 1, 1, 0, "R1 top index mismatch");
        issue(2'd0, 4'hD, 0, 4'h0, 1, 1, 1, 0, "R1 index zero distinct");
        issue(2'd3, 4'h0, 63, 4'h0, 1, 1, 1, 0, "R10 init top block");
        issue(2'd1, 4'hD, 63, 4'h0, 1, 1, 1, 0, "R11 bypass after init");
        idle();
        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R2 missing responses act=%0d exp=0", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL R2 watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule